// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Register

This block holds the status byte of one asynchronous serial channel. It sits between the receive and transmit shifter logic and the CPU bus. It records when a received byte has been placed in the receive holding register, when a second byte arrives before the first was read (overrun), and whether the accepted byte carried a parity or framing error. It also passes through the transmit-holding-empty state and a synchronized carrier-detect level. The two interrupt-enable bits are the only CPU-writable fields.

The receive flags clear from several sources: a CPU read of the receive holding register, carrier-detect high, the I/O-stop mode input, or a write of 0 to the error-flag-reset control bit. A single active-high interrupt request merges the receive and transmit conditions through their enables. The status byte is always presented on `status`, so a CPU read needs no strobe.

Top module: `ser_chan_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status` reads 0x00 with `tx_empty` low and `irq` is 0.
- R2: The `status` bit positions are: bit 7 receive full, bit 6 overrun, bit 5 parity error, bit 4 framing error, bit 3 receive interrupt enable, bit 2 carrier detect, bit 1 transmit empty, bit 0 transmit interrupt enable. Bit 1 follows `tx_empty` in the same cycle.
- R3: A `st_wr` pulse loads bit 3 and bit 0 from `st_wdata[3]` and `st_wdata[0]`. All other bits of `st_wdata` have no effect.
- R4: An `rx_load` pulse while receive full is 0 sets receive full at the next edge. This happens even when `rx_perr` or `rx_ferr` is high. Bits 5 and 4 take the values of `rx_perr` and `rx_ferr`.
- R5: Receive full clears at the next edge after `rx_data_rd`, synchronized carrier detect high, or `io_stop` high. An accepted `rx_load` in the same cycle wins over these clears.
- R6: `rx_shift_full` while receive full is 1 sets overrun at the next edge. While receive full is 1, `rx_load` is ignored: bits 5 and 4 keep the first byte's values.
- R7: Overrun, parity error and framing error clear at the next edge after `efr_wr` with `efr_val`=0, synchronized carrier detect high, or `io_stop` high. A CPU read does not clear them, and `efr_wr` with `efr_val`=1 does not clear them. A set in the same cycle wins over a clear.
- R8: Bit 2 shows `cd_in` after two clock edges. That synchronized value is also the carrier-detect clear source.
- R9: `irq` is 1 exactly when one of these holds: bit 3 is set and any of bits 7, 6, 5, 4 or 2 is set; or bits 0 and 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_load | input | 1 | Received byte transferred to holding register |
| rx_perr | input | 1 | Parity error of the byte being loaded |
| rx_ferr | input | 1 | Framing error of the byte being loaded |
| rx_shift_full | input | 1 | Receive shift register has completed a byte |
| tx_empty | input | 1 | Transmit holding register empty |
| cd_in | input | 1 | Asynchronous carrier-detect level |
| io_stop | input | 1 | I/O-stop mode active |
| rx_data_rd | input | 1 | CPU read of receive holding register |
| efr_wr | input | 1 | Write strobe of error-flag-reset bit |
| efr_val | input | 1 | Value written to error-flag-reset bit |
| st_wr | input | 1 | CPU write strobe for the status byte |
| st_wdata | input | 8 | CPU write data for the status byte |
| status | output | 8 | Assembled status byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The receive flags, the error flags and the enables are due one edge after the strobe that changes them. The carrier-detect bit, and any clear it causes, lag `cd_in` by two edges and three edges. The transmit-empty bit and `irq` follow their inputs within the same cycle. The bench drives inputs on the falling edge and updates its reference model at the rising edge, using the inputs held there. It compares every bit and `irq` at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/ser_chan_status.sv
`timescale 1ns/1ps
module ser_chan_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_load,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_shift_full,
  input  logic       tx_empty,
  input  logic       cd_in,
  input  logic       io_stop,
  input  logic       rx_data_rd,
  input  logic       efr_wr,
  input  logic       efr_val,
  input  logic       st_wr,
  input  logic [7:0] st_wdata,
  output logic [7:0] status,
  output logic       irq
);
  logic cd_meta, cd_sync;
  logic full, ovr, perr, ferr, rie, tie;

  wire accept  = rx_load & ~full;
  wire clr_all = cd_sync | io_stop;
  wire clr_err = (efr_wr & ~efr_val) | clr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_meta <= 1'b0;
      cd_sync <= 1'b0;
    end else begin
      cd_meta <= cd_in;
      cd_sync <= cd_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      ovr  <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      if (accept) full <= 1'b1;
      else if (rx_data_rd | clr_all) full <= 1'b0;

      if (rx_shift_full & full) ovr <= 1'b1;
      else if (clr_err) ovr <= 1'b0;

      if (accept) begin
        perr <= rx_perr;
        ferr <= rx_ferr;
      end else if (clr_err) begin
        perr <= 1'b0;
        ferr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie <= 1'b0;
      tie <= 1'b0;
    end else if (st_wr) begin
      rie <= st_wdata[3];
      tie <= st_wdata[0];
    end
  end

  assign status = {full, ovr, perr, ferr, rie, cd_sync, tx_empty, tie};
  assign irq    = (rie & (full | ovr | perr | ferr | cd_sync)) | (tie & tx_empty);
endmodule

module ser_chan_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_load,
  input logic       rx_shift_full,
  input logic       io_stop,
  input logic       efr_wr,
  input logic       efr_val,
  input logic       st_wr,
  input logic [7:0] st_wdata,
  input logic [7:0] status,
  input logic       irq
);
  // R4
  rx_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && !status[7] |=> status[7]);
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_shift_full && status[7] |=> status[6]);
  // R6
  discard_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] && !io_stop && !status[2] && !(efr_wr && !efr_val)
    |=> $stable(status[5:4]));
  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] && !io_stop && !status[2] && !(efr_wr && !efr_val) |=> status[6]);
  // R5
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_stop && !rx_load |=> !status[7]);
  // R3
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> status[3] == $past(st_wdata[3]) && status[0] == $past(st_wdata[0]));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] && !status[0] |-> !irq);
endmodule

bind ser_chan_status ser_chan_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_shift_full(rx_shift_full),
  .io_stop(io_stop), .efr_wr(efr_wr), .efr_val(efr_val), .st_wr(st_wr),
  .st_wdata(st_wdata), .status(status), .irq(irq));

// File: tb/sim_ser_chan_status.sv
`timescale 1ns/1ps
module sim_ser_chan_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_load = 0, rx_perr = 0, rx_ferr = 0, rx_shift_full = 0, tx_empty = 0;
  logic cd_in = 0, io_stop = 0, rx_data_rd = 0, efr_wr = 0, efr_val = 0, st_wr = 0;
  logic [7:0] st_wdata = 8'h00;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic m_full, m_ovr, m_pe, m_fe, m_rie, m_tie, m_cd1, m_cd2;

  always #5 clk = ~clk;

  ser_chan_status u0 (.*);

  function automatic string req_of(int b);
    case (b)
      7: return "R5"; 6: return "R6"; 5, 4: return "R7";
      3, 0: return "R3"; 2: return "R8"; default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_full, m_ovr, m_pe, m_fe, m_rie, m_cd2, tx_empty, m_tie};
  endfunction

  function automatic logic exp_irq();
    return (m_rie & (m_full | m_ovr | m_pe | m_fe | m_cd2)) | (m_tie & tx_empty);
  endfunction

  task automatic model_reset();
    {m_full, m_ovr, m_pe, m_fe, m_rie, m_tie, m_cd1, m_cd2} = '0;
  endtask

  task automatic model_step();
    logic acc, ca, ce, nf, no, np, nfe;
    acc = rx_load & ~m_full;
    ca  = m_cd2 | io_stop;
    ce  = (efr_wr & ~efr_val) | ca;
    nf  = acc ? 1'b1 : ((rx_data_rd | ca) ? 1'b0 : m_full);
    no  = (rx_shift_full & m_full) ? 1'b1 : (ce ? 1'b0 : m_ovr);
    np  = acc ? rx_perr : (ce ? 1'b0 : m_pe);
    nfe = acc ? rx_ferr : (ce ? 1'b0 : m_fe);
    if (st_wr) begin m_rie = st_wdata[3]; m_tie = st_wdata[0]; end
    m_full = nf; m_ovr = no; m_pe = np; m_fe = nfe;
    m_cd2 = m_cd1; m_cd1 = cd_in;
  endtask

  task automatic compare(string tag);
    logic [7:0] e;
    e = exp_status();
    for (int b = 0; b < 8; b++) begin
      checks++;
      if (status[b] !== e[b]) begin
        errors++;
        $display("FAIL %s %s bit%0d actual %b expected %b", req_of(b), tag, b, status[b], e[b]);
      end
    end
    checks++;
    if (irq !== exp_irq()) begin
      errors++;
      $display("FAIL R9 %s irq actual %b expected %b", tag, irq, exp_irq());
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    rx_load = 0; rx_perr = 0; rx_ferr = 0; rx_shift_full = 0;
    io_stop = 0; rx_data_rd = 0; efr_wr = 0; efr_val = 0; st_wr = 0;
  endtask

  task automatic expect_bit(int b, logic v, string req);
    checks++;
    if (status[b] !== v) begin
      errors++;
      $display("FAIL %s directed bit%0d actual %b expected %b", req, b, status[b], v);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    cyc("R1 after release");

    // R3: enable write ignores other bits
    st_wr = 1; st_wdata = 8'hF6; cyc("R3 write");
    expect_bit(3, 1'b0, "R3"); expect_bit(7, 1'b0, "R3");
    st_wdata = 8'h09; cyc("R3 write2"); idle(); cyc("R3 hold");
    expect_bit(3, 1'b1, "R3"); expect_bit(0, 1'b1, "R3");

    // R4: error byte still sets full; R9 with tx_empty
    tx_empty = 1; rx_load = 1; rx_perr = 1; cyc("R4 error byte"); idle();
    expect_bit(7, 1'b1, "R4"); expect_bit(5, 1'b1, "R4");
    // R6: second byte discarded, overrun set
    rx_load = 1; rx_ferr = 1; rx_shift_full = 1; cyc("R6 overrun"); idle();
    expect_bit(6, 1'b1, "R6"); expect_bit(4, 1'b0, "R6");
    // R7: read clears full but not overrun; efr=1 no effect
    rx_data_rd = 1; cyc("R7 read"); idle();
    expect_bit(7, 1'b0, "R5"); expect_bit(6, 1'b1, "R7");
    efr_wr = 1; efr_val = 1; cyc("R7 efr one"); idle();
    expect_bit(6, 1'b1, "R7");
    // R5: load beats read clear
    rx_load = 1; rx_data_rd = 1; cyc("R5 priority"); idle();
    expect_bit(7, 1'b1, "R5");
    // R7: set beats efr clear
    rx_shift_full = 1; efr_wr = 1; efr_val = 0; cyc("R7 priority"); idle();
    expect_bit(6, 1'b1, "R7");
    efr_wr = 1; efr_val = 0; cyc("R7 efr zero"); idle();
    expect_bit(6, 1'b0, "R7"); expect_bit(5, 1'b0, "R7");
    // R8: carrier detect after two edges clears full
    cd_in = 1; cyc("R8 edge1"); expect_bit(2, 1'b0, "R8");
    cyc("R8 edge2"); expect_bit(2, 1'b1, "R8");
    cyc("R8 clear"); expect_bit(7, 1'b0, "R8");
    cd_in = 0; cyc("R8 low1"); cyc("R8 low2");
    // R5: io_stop clears full
    rx_load = 1; cyc("R5 load"); idle(); io_stop = 1; cyc("R5 stop"); idle();
    expect_bit(7, 1'b0, "R5");

    for (int i = 0; i < 3000; i++) begin
      rx_load       = ($urandom % 4) == 0;
      rx_perr       = $urandom % 2;
      rx_ferr       = $urandom % 2;
      rx_shift_full = ($urandom % 5) == 0;
      tx_empty      = $urandom % 2;
      io_stop       = ($urandom % 24) == 0;
      rx_data_rd    = ($urandom % 5) == 0;
      efr_wr        = ($urandom % 7) == 0;
      efr_val       = $urandom % 2;
      st_wr         = ($urandom % 12) == 0;
      st_wdata      = 8'($urandom);
      if (($urandom % 40) == 0) cd_in = ~cd_in;
      cyc("random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule